// File: doc/BRIEF.md
# IDE DMA Transfer Sequencer

This block runs one disk or optical-drive DMA command across a series of descriptor chunks. A start pulse loads the command: the drive kind, the command kind, the starting block address, the sector count and the packet byte size. From these it sets a signed count of remaining bytes and clears a running buffer index. Each chunk that the descriptor engine then presents is turned into one request for the byte aligner. The request carries a device byte offset, a byte count, a memory address and a direction. When the aligner reports completion, the sequencer moves the index forward and reduces the remaining count.

Disk and optical commands scale the block address by different factors. An optical command whose block address is all ones is a reply that has no block address. Its data goes out as a single direct-copy request, and the command then ends. If a chunk arrives while the DMA channel is not active, the sequencer drops the chunk without finishing it and waits for the engine to present it again. The command ends in one of two ways. On success the status byte shows ready and seek and a single-cycle interrupt fires. On an error the status byte shows ready and error, and the remainder is cleared.

Top module: `ide_dma_seq`

## Requirements
- R1: After reset, statusByte is 0x00, and irqPulse, dmaActive, reqValid and chunkDone are all 0. A start pulse sets dmaActive to 1, clears the buffer index to 0 and loads the remaining byte count. For a disk the count is sectorCnt×512. For an optical drive it is packetBytes.
- R2: For a disk command, reqOffset = lbaIn×512 + buffer index. The buffer index advances by the chunk length each time a transfer completes successfully.
- R3: For an optical command, reqOffset = lbaIn×2048 + buffer index.
- R4: Each disk data chunk that is issued lowers sectorsLeft by (chunkLen+511)>>9. Optical commands leave sectorsLeft unchanged.
- R5: A chunk presented while dmaActive is 0 or dmaGate is 0 produces no request, no chunkDone and no status change. chunkBusy stays 0.
- R6: When the remaining byte count is zero or below, either as a chunk arrives or after a successful completion, the block does all of the following in the same cycle: statusByte becomes 0x50 (ready 0x40 plus seek 0x10), irqPulse fires, chunkDone pulses and dmaActive clears.
- R7: A zero-length chunk on an active command, with bytes still remaining, pulses chunkDone. It issues no request, raises no interrupt and leaves dmaActive at 1.
- R8: For an optical command with lbaIn all ones, the block issues one request with reqCopy=1 and reqBytes = min(remaining bytes, chunkLen). In the same cycle statusByte becomes 0x50, irqPulse fires and dmaActive clears.
- R9: A completion with xferErr=1 does all of the following in one cycle: sets statusByte to 0x41 (ready 0x40 plus error 0x01), fires irqPulse, pulses remainderClr and chunkDone, and clears dmaActive.
- R10: cmdKind encodes read as 0, write as 1 and trim as 2. A trim chunk pulses chunkDone and issues no request.
- R11: reqWrite is 1 for a write command and 0 for a read. irqPulse never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Loads a new command |
| isOptical | input | 1 | 1 for an optical drive (2048-byte blocks), 0 for a disk |
| cmdKind | input | 2 | 0 read, 1 write, 2 trim |
| lbaIn | input | LBA_W | Starting block address; all ones on optical means no address |
| sectorCnt | input | SEC_W | Disk sector count |
| packetBytes | input | BUF_W | Optical packet transfer size in bytes |
| dmaGate | input | 1 | Channel-active gate from the descriptor engine |
| chunkValid | input | 1 | A descriptor chunk is presented |
| chunkLen | input | LEN_W | Chunk length in bytes |
| chunkAddr | input | ADDR_W | Chunk memory address |
| xferDone | input | 1 | Aligner finished the outstanding request |
| xferErr | input | 1 | Completion carries an error |
| reqValid | output | 1 | One-cycle request to the aligner |
| reqWrite | output | 1 | Request writes to the device |
| reqCopy | output | 1 | Request is a direct copy of reply data |
| reqOffset | output | LBA_W+12 | Device byte offset |
| reqBytes | output | LEN_W | Request byte count |
| reqAddr | output | ADDR_W | Request memory address |
| statusByte | output | 8 | Drive status byte |
| irqPulse | output | 1 | One-cycle interrupt |
| chunkDone | output | 1 | One-cycle end of the current chunk |
| chunkBusy | output | 1 | A request is outstanding |
| remainderClr | output | 1 | One-cycle clear of the remainder length |
| dmaActive | output | 1 | Command is active |
| sectorsLeft | output | SEC_W | Remaining disk sector count |

## Verification
The bench walks a multi-chunk disk write and checks the offset and the sector count after every step. A wrong scale factor or an index that never advances shows up as offsets that stay put or jump too far. An optical read checks the 2048-byte scaling, and a reply with no block address must be clipped to the smaller of the remaining size and the chunk length. A copy path that ignored this would send the whole chunk. The bench also covers a chunk that arrives while the gate is closed, and another after the command has ended. A design that got this wrong would issue a request or finish the chunk early. Further checks cover zero-length and trim chunks, an error completion and a zero-sector command. Each of these would otherwise end the command too early, raise a spurious interrupt or set the wrong status code.

// File: rtl/ide_dma_seq_pkg.sv
package ide_dma_seq_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_TRIM  = 2'd2
  } cmdKind_e;

  localparam logic [7:0] ST_READY = 8'h40;
  localparam logic [7:0] ST_SEEK  = 8'h10;
  localparam logic [7:0] ST_ERR   = 8'h01;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // new command
    logic issue;   // block data request
    logic copy;    // direct-copy request
    logic commit;  // advance index after success
    logic finOk;   // good ending
    logic finErr;  // error ending
    logic done;    // end current chunk
  } seqStrobe_t;
endpackage

// File: rtl/ide_dma_seq_ctrl.sv
module ide_dma_seq_ctrl
  import ide_dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       chunkValid,
  input  logic       dmaGate,
  input  logic       xferDone,
  input  logic       xferErr,
  input  logic       remLE0,
  input  logic       lenZero,
  input  logic       noLba,
  input  logic       isTrim,
  input  logic       remAfterLE0,
  output seqStrobe_t stb,
  output logic       actFlag,
  output logic       busy
);
  typedef enum logic {S_IDLE, S_WAIT} state_e;
  state_e state, nextState;
  logic nextAct;

  always_comb begin
    stb       = '0;
    nextState = state;
    nextAct   = actFlag;
    if (startPulse) begin
      stb.load  = 1'b1;
      nextAct   = 1'b1;
      nextState = S_IDLE;
    end else begin
      unique case (state)
        S_IDLE: if (chunkValid && actFlag && dmaGate) begin
          if (remLE0) begin
            stb.finOk = 1'b1; stb.done = 1'b1; nextAct = 1'b0;
          end else if (lenZero || isTrim) begin
            stb.done = 1'b1;
          end else if (noLba) begin
            stb.copy = 1'b1; stb.finOk = 1'b1; stb.done = 1'b1; nextAct = 1'b0;
          end else begin
            stb.issue = 1'b1; nextState = S_WAIT;
          end
        end
        S_WAIT: if (xferDone) begin
          nextState = S_IDLE;
          stb.done  = 1'b1;
          if (xferErr) begin
            stb.finErr = 1'b1; nextAct = 1'b0;
          end else begin
            stb.commit = 1'b1;
            if (remAfterLE0) begin
              stb.finOk = 1'b1; nextAct = 1'b0;
            end
          end
        end
        default: nextState = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      actFlag <= 1'b0;
    end else begin
      state   <= nextState;
      actFlag <= nextAct;
    end
  end

  assign busy = (state == S_WAIT);
endmodule

// File: rtl/ide_dma_seq_dp.sv
module ide_dma_seq_dp
  import ide_dma_seq_pkg::*;
#(
  parameter int LBA_W  = 32,
  parameter int SEC_W  = 16,
  parameter int BUF_W  = 24,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic              isOptical,
  input  logic [1:0]        cmdKind,
  input  logic [LBA_W-1:0]  lbaIn,
  input  logic [SEC_W-1:0]  sectorCnt,
  input  logic [BUF_W-1:0]  packetBytes,
  input  logic [LEN_W-1:0]  chunkLen,
  input  logic [ADDR_W-1:0] chunkAddr,
  output logic              remLE0,
  output logic              lenZero,
  output logic              noLba,
  output logic              isTrim,
  output logic              remAfterLE0,
  output logic              reqValid,
  output logic              reqWrite,
  output logic              reqCopy,
  output logic [LBA_W+11:0] reqOffset,
  output logic [LEN_W-1:0]  reqBytes,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        statusByte,
  output logic              irqPulse,
  output logic              chunkDone,
  output logic              remainderClr,
  output logic [SEC_W-1:0]  sectorsLeft
);
  localparam int SZ_W  = (BUF_W > SEC_W + 9) ? BUF_W : SEC_W + 9;
  localparam int REM_W = SZ_W + 1;
  localparam int OFF_W = LBA_W + 12;

  logic signed [REM_W-1:0] remBytes, remAfter;
  logic [SZ_W-1:0]  bufIdx;
  logic [LBA_W-1:0] lbaReg;
  logic             optReg;
  cmdKind_e         kindReg;
  logic [LEN_W-1:0] lenReg;
  logic [OFF_W-1:0] offNow;
  logic [LEN_W-1:0] copyBytes;
  logic [SEC_W-1:0] chunkSecs;
  logic [LEN_W:0]   lenRound;

  assign remLE0      = remBytes[REM_W-1] || (remBytes == '0);
  assign remAfter    = remBytes - $signed(REM_W'(lenReg));
  assign remAfterLE0 = remAfter[REM_W-1] || (remAfter == '0);
  assign lenZero     = (chunkLen == '0);
  assign noLba       = optReg && (&lbaReg);
  assign isTrim      = (kindReg == CMD_TRIM);

  assign offNow    = (OFF_W'(lbaReg) << (optReg ? 11 : 9)) + OFF_W'(bufIdx);
  assign copyBytes = (REM_W'(chunkLen) > remBytes) ? LEN_W'(remBytes) : chunkLen;
  assign lenRound  = {1'b0, chunkLen} + (LEN_W+1)'(511);
  assign chunkSecs = SEC_W'(lenRound >> 9);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remBytes <= '0; bufIdx <= '0; lbaReg <= '0; optReg <= 1'b0;
      kindReg <= CMD_READ; lenReg <= '0; sectorsLeft <= '0;
      reqValid <= 1'b0; reqWrite <= 1'b0; reqCopy <= 1'b0;
      reqOffset <= '0; reqBytes <= '0; reqAddr <= '0;
      statusByte <= 8'h00; irqPulse <= 1'b0; chunkDone <= 1'b0;
      remainderClr <= 1'b0;
    end else begin
      reqValid     <= 1'b0;
      irqPulse     <= 1'b0;
      chunkDone    <= 1'b0;
      remainderClr <= 1'b0;
      if (stb.load) begin
        remBytes    <= isOptical ? $signed(REM_W'(packetBytes))
                                 : $signed(REM_W'({sectorCnt, 9'b0}));
        bufIdx      <= '0;
        lbaReg      <= lbaIn;
        optReg      <= isOptical;
        kindReg     <= cmdKind_e'(cmdKind);
        sectorsLeft <= sectorCnt;
        statusByte  <= 8'h00;
      end
      if (stb.issue) begin
        reqValid  <= 1'b1;
        reqCopy   <= 1'b0;
        reqWrite  <= (kindReg == CMD_WRITE);
        reqOffset <= offNow;
        reqBytes  <= chunkLen;
        reqAddr   <= chunkAddr;
        lenReg    <= chunkLen;
        if (!optReg) sectorsLeft <= sectorsLeft - chunkSecs;
      end
      if (stb.copy) begin
        reqValid  <= 1'b1;
        reqCopy   <= 1'b1;
        reqWrite  <= 1'b0;
        reqOffset <= '0;
        reqBytes  <= copyBytes;
        reqAddr   <= chunkAddr;
      end
      if (stb.commit) begin
        remBytes <= remAfter;
        bufIdx   <= bufIdx + SZ_W'(lenReg);
      end
      if (stb.finOk) begin
        statusByte <= ST_READY | ST_SEEK;
        irqPulse   <= 1'b1;
      end
      if (stb.finErr) begin
        statusByte   <= ST_READY | ST_ERR;
        irqPulse     <= 1'b1;
        remainderClr <= 1'b1;
      end
      if (stb.done) chunkDone <= 1'b1;
    end
  end
endmodule

// File: rtl/ide_dma_seq.sv
module ide_dma_seq
  import ide_dma_seq_pkg::*;
#(
  parameter int LBA_W  = 32,
  parameter int SEC_W  = 16,
  parameter int BUF_W  = 24,
  parameter int LEN_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              isOptical,
  input  logic [1:0]        cmdKind,
  input  logic [LBA_W-1:0]  lbaIn,
  input  logic [SEC_W-1:0]  sectorCnt,
  input  logic [BUF_W-1:0]  packetBytes,
  input  logic              dmaGate,
  input  logic              chunkValid,
  input  logic [LEN_W-1:0]  chunkLen,
  input  logic [ADDR_W-1:0] chunkAddr,
  input  logic              xferDone,
  input  logic              xferErr,
  output logic              reqValid,
  output logic              reqWrite,
  output logic              reqCopy,
  output logic [LBA_W+11:0] reqOffset,
  output logic [LEN_W-1:0]  reqBytes,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [7:0]        statusByte,
  output logic              irqPulse,
  output logic              chunkDone,
  output logic              chunkBusy,
  output logic              remainderClr,
  output logic              dmaActive,
  output logic [SEC_W-1:0]  sectorsLeft
);
  seqStrobe_t stb;
  logic remLE0, lenZero, noLba, isTrim, remAfterLE0;

  ide_dma_seq_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .chunkValid(chunkValid),
    .dmaGate(dmaGate), .xferDone(xferDone), .xferErr(xferErr),
    .remLE0(remLE0), .lenZero(lenZero), .noLba(noLba), .isTrim(isTrim),
    .remAfterLE0(remAfterLE0), .stb(stb), .actFlag(dmaActive), .busy(chunkBusy)
  );

  ide_dma_seq_dp #(
    .LBA_W(LBA_W), .SEC_W(SEC_W), .BUF_W(BUF_W), .LEN_W(LEN_W), .ADDR_W(ADDR_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .isOptical(isOptical), .cmdKind(cmdKind),
    .lbaIn(lbaIn), .sectorCnt(sectorCnt), .packetBytes(packetBytes),
    .chunkLen(chunkLen), .chunkAddr(chunkAddr),
    .remLE0(remLE0), .lenZero(lenZero), .noLba(noLba), .isTrim(isTrim),
    .remAfterLE0(remAfterLE0), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCopy(reqCopy), .reqOffset(reqOffset), .reqBytes(reqBytes),
    .reqAddr(reqAddr), .statusByte(statusByte), .irqPulse(irqPulse),
    .chunkDone(chunkDone), .remainderClr(remainderClr), .sectorsLeft(sectorsLeft)
  );
endmodule

// File: rtl/ide_dma_seq_chk.sv
module ide_dma_seq_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startPulse,
  input logic             chunkValid,
  input logic             dmaGate,
  input logic [LEN_W-1:0] chunkLen,
  input logic             xferDone,
  input logic             xferErr,
  input logic             reqValid,
  input logic             reqCopy,
  input logic             chunkBusy,
  input logic             chunkDone,
  input logic             irqPulse,
  input logic [7:0]       statusByte,
  input logic             dmaActive
);
  assert_irq_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

  assert_irq_ends_cmd_R6: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> !dmaActive);

  assert_gate_park_R5: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && !dmaGate && !chunkBusy && !startPulse) |=> (!reqValid && !chunkDone));

  assert_zero_len_no_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    (chunkValid && chunkLen == '0 && !chunkBusy && !startPulse) |=> !reqValid);

  assert_err_status_R9: assert property (@(posedge clk) disable iff (!rstN)
    (xferDone && xferErr && chunkBusy && !startPulse)
      |=> (irqPulse && statusByte == 8'h41 && !dmaActive && chunkDone));

  assert_block_req_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqCopy) |-> chunkBusy);
endmodule

bind ide_dma_seq ide_dma_seq_chk #(.LEN_W(LEN_W)) i_chk (
  .clk(clk), .rstN(rstN), .startPulse(startPulse), .chunkValid(chunkValid),
  .dmaGate(dmaGate), .chunkLen(chunkLen), .xferDone(xferDone), .xferErr(xferErr),
  .reqValid(reqValid), .reqCopy(reqCopy), .chunkBusy(chunkBusy),
  .chunkDone(chunkDone), .irqPulse(irqPulse), .statusByte(statusByte),
  .dmaActive(dmaActive)
);

// File: tb/test_ide_dma_seq.sv
module test_ide_dma_seq;
  localparam int LBA_W = 32, SEC_W = 16, BUF_W = 24, LEN_W = 16, ADDR_W = 32;

  logic clk = 1'b0, rstN = 1'b0;
  logic startPulse = 0, isOptical = 0, dmaGate = 1, chunkValid = 0;
  logic xferDone = 0, xferErr = 0;
  logic [1:0] cmdKind = 0;
  logic [LBA_W-1:0] lbaIn = 0;
  logic [SEC_W-1:0] sectorCnt = 0;
  logic [BUF_W-1:0] packetBytes = 0;
  logic [LEN_W-1:0] chunkLen = 0;
  logic [ADDR_W-1:0] chunkAddr = 0;
  logic reqValid, reqWrite, reqCopy, irqPulse, chunkDone, chunkBusy, remainderClr, dmaActive;
  logic [LBA_W+11:0] reqOffset;
  logic [LEN_W-1:0] reqBytes;
  logic [ADDR_W-1:0] reqAddr;
  logic [7:0] statusByte;
  logic [SEC_W-1:0] sectorsLeft;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ide_dma_seq i_ide_dma_seq (.*);

  // disk write table: chunk length, expected offset, expected sectors left, final chunk
  localparam logic [15:0] V_LEN [3] = '{16'd512, 16'd1024, 16'd512};
  localparam logic [43:0] V_OFF [3] = '{44'h20000, 44'h20200, 44'h20600};
  localparam logic [15:0] V_SEC [3] = '{16'd3, 16'd1, 16'd0};
  localparam logic        V_FIN [3] = '{1'b0, 1'b0, 1'b1};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic startCmd(input logic opt, input logic [1:0] kind,
                          input logic [31:0] lba, input logic [15:0] secs,
                          input logic [23:0] pkt);
    @(negedge clk);
    isOptical = opt; cmdKind = kind; lbaIn = lba; sectorCnt = secs; packetBytes = pkt;
    startPulse = 1;
    @(negedge clk);
    startPulse = 0;
  endtask

  task automatic sendChunk(input logic [15:0] len, input logic [31:0] addr);
    @(negedge clk);
    chunkValid = 1; chunkLen = len; chunkAddr = addr;
    @(negedge clk);
    chunkValid = 0;
  endtask

  task automatic complete(input logic err);
    @(negedge clk);
    xferDone = 1; xferErr = err;
    @(negedge clk);
    xferDone = 0; xferErr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status reset", statusByte, 8'h00);
    chk("R1 irq reset", irqPulse, 0);
    chk("R1 active reset", dmaActive, 0);
    chk("R1 req reset", reqValid, 0);

    // disk write walk: R1 R2 R4 R6 R11
    startCmd(0, 2'd1, 32'h100, 16'd4, 24'd0);
    chk("R1 active after start", dmaActive, 1);
    for (int i = 0; i < 3; i++) begin
      sendChunk(V_LEN[i], 32'h1000 + 32'(i));
      chk("R2 req valid", reqValid, 1);
      chk("R2 disk offset", reqOffset, V_OFF[i]);
      chk("R11 write dir", reqWrite, 1);
      chk("R2 addr", reqAddr, 32'h1000 + 32'(i));
      chk("R4 sectors left", sectorsLeft, V_SEC[i]);
      complete(0);
      chk("R6 chunk done", chunkDone, 1);
      chk("R6 irq on final", irqPulse, V_FIN[i]);
      chk("R6 active", dmaActive, !V_FIN[i]);
      chk("R6 status", statusByte, V_FIN[i] ? 8'h50 : 8'h00);
    end
    @(negedge clk);
    chk("R11 irq single cycle", irqPulse, 0);

    // R5 chunk after command ended is parked
    sendChunk(16'd512, 32'h2000);
    chk("R5 no req after end", reqValid, 0);
    chk("R5 no done after end", chunkDone, 0);

    // optical read: R3 R4 R11
    startCmd(1, 2'd0, 32'd5, 16'd7, 24'd4096);
    sendChunk(16'd2048, 32'h3000);
    chk("R3 optical offset", reqOffset, 44'h2800);
    chk("R11 read dir", reqWrite, 0);
    chk("R4 optical keeps sectors", sectorsLeft, 16'd7);
    complete(0);
    chk("R6 not yet final", irqPulse, 0);
    sendChunk(16'd2048, 32'h3800);
    chk("R3 optical offset 2", reqOffset, 44'h3000);
    complete(0);
    chk("R6 optical finish irq", irqPulse, 1);
    chk("R6 optical status", statusByte, 8'h50);

    // R8 no-address reply, clipped to remaining size
    startCmd(1, 2'd0, 32'hFFFF_FFFF, 16'd0, 24'd18);
    sendChunk(16'd256, 32'h4000);
    chk("R8 copy flag", reqCopy, 1);
    chk("R8 copy bytes clipped", reqBytes, 16'd18);
    chk("R8 irq", irqPulse, 1);
    chk("R8 status", statusByte, 8'h50);
    chk("R8 active cleared", dmaActive, 0);
    startCmd(1, 2'd0, 32'hFFFF_FFFF, 16'd0, 24'd300);
    sendChunk(16'd100, 32'h4100);
    chk("R8 copy bytes by chunk", reqBytes, 16'd100);

    // R5 closed gate parks, reopening proceeds
    startCmd(0, 2'd0, 32'd0, 16'd2, 24'd0);
    dmaGate = 0;
    sendChunk(16'd512, 32'h5000);
    chk("R5 gate closed no req", reqValid, 0);
    chk("R5 gate closed no done", chunkDone, 0);
    chk("R5 gate closed not busy", chunkBusy, 0);
    chk("R5 still active", dmaActive, 1);
    dmaGate = 1;
    sendChunk(16'd512, 32'h5000);
    chk("R5 reopened req", reqValid, 1);
    chk("R5 reopened offset", reqOffset, 44'h0);

    // R9 error completion
    complete(1);
    chk("R9 status", statusByte, 8'h41);
    chk("R9 irq", irqPulse, 1);
    chk("R9 remainder clear", remainderClr, 1);
    chk("R9 done", chunkDone, 1);
    chk("R9 inactive", dmaActive, 0);

    // R7 zero-length chunk
    startCmd(0, 2'd0, 32'd1, 16'd1, 24'd0);
    sendChunk(16'd0, 32'h6000);
    chk("R7 done", chunkDone, 1);
    chk("R7 no req", reqValid, 0);
    chk("R7 no irq", irqPulse, 0);
    chk("R7 still active", dmaActive, 1);

    // R10 trim
    startCmd(0, 2'd2, 32'd1, 16'd1, 24'd0);
    sendChunk(16'd512, 32'h7000);
    chk("R10 done", chunkDone, 1);
    chk("R10 no req", reqValid, 0);

    // R6 zero-sector command finishes on first chunk
    startCmd(0, 2'd0, 32'd9, 16'd0, 24'd0);
    sendChunk(16'd512, 32'h8000);
    chk("R6 empty no req", reqValid, 0);
    chk("R6 empty irq", irqPulse, 1);
    chk("R6 empty status", statusByte, 8'h50);
    chk("R6 empty inactive", dmaActive, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule